// File: doc/BRIEF.md
# 16:1 Serializer with Selectable Load Phase

This block turns a 16-bit parallel word into a serial bit stream. Each word period lasts sixteen bit clocks, and one serial bit leaves the block on each of them, with the highest bit first. The block divides the bit clock by sixteen to make a word clock, which the upstream logic uses to pace its parallel data. The block captures the parallel word at one of four points in the word period. These points sit a quarter period apart and are measured from the rising edge of the word clock. A load strobe marks the bit clock in which the capture takes place.

The serial output comes from one of two sources. One is the serializer. The other is a serial bypass input, which passes to the output through logic only, with no register in the path. For test, a select input can swap a test clock in for the bit clock, and all internal logic then runs from the test clock.

The reset input is asynchronous and active low. Its release is synchronised to the active core clock with two flops, so the counter starts to run on the third rising core-clock edge after reset is released.

Top module: `ser16_tx`

## Requirements
- R1: While `rst_n` is low, `word_clk` is 1, `load_pulse` is 0, and `ser_out` is 0 when `src_sel` is 1.
- R2: `word_clk` is high for 8 core clocks and low for 8 core clocks, so its period is 16 core clocks. The cycle in which it rises is count 0 of a word.
- R3: `load_pulse` is high for exactly one core clock in each word. It falls on count 0, 4, 8 or 12, chosen by `phase_sel` as follows: 2'b11 gives 0, 2'b10 gives 4, 2'b01 gives 8 and 2'b00 gives 12.
- R4: The word present on `par_data` in a `load_pulse` cycle appears on `ser_out` over the next 16 core clocks, in the order bit 15, bit 14, and so on down to bit 0.
- R5: Changes on `par_data` outside the `load_pulse` cycle have no effect on the serial stream.
- R6: A new `phase_sel` value takes effect only at the next word boundary, which is the cycle in which `word_clk` rises. Loads in the current word keep the old offset.
- R7: When `src_sel` is 0, `ser_out` follows `byp_in` with no clock delay. The serializer keeps running while the bypass is selected.
- R8: When `test_clk_sel` is 1, `clk_test` clocks all logic. `word_clk` then has a period of 16 `clk_test` periods, and `clk_bit` has no effect on it.
- R9: After `rst_n` rises, the first `load_pulse` occurs in the cycle after the second core-clock rising edge. The first word after reset uses the 0 offset whatever `phase_sel` is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_bit | input | 1 | Normal bit clock |
| clk_test | input | 1 | Test clock, used when `test_clk_sel` is 1 |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_clk_sel | input | 1 | 1 selects `clk_test` as the core clock |
| src_sel | input | 1 | 1 selects the serializer, 0 selects `byp_in` |
| phase_sel | input | 2 | Load offset select (11/10/01/00 gives 0/4/8/12 counts) |
| par_data | input | 16 | Parallel word input |
| byp_in | input | 1 | Serial bypass input |
| ser_out | output | 1 | Serial output |
| word_clk | output | 1 | Core clock divided by 16 |
| load_pulse | output | 1 | High in the cycle in which `par_data` is captured |

## Verification
In the cycle whose count equals the selected offset, `load_pulse` and the registered `word_clk` are both already valid. The captured word's bit 15 reaches `ser_out` one core-clock edge later, and bit 0 follows on the sixteenth edge. The bypass path has no register, and a phase change is applied on the edge that ends count 15. After reset release, the first load cycle comes after two edges and the first serial bit after three. The bench locks onto the rising edge of `word_clk`, numbers the cycles from it, and samples every output on the falling edge of `clk_bit`. The one exception is the bypass, which is sampled a few nanoseconds after its input changes and before the next edge. In test-clock mode, the bench counts falling edges of each clock between two rising edges of `word_clk`.

// File: rtl/ser16_pkg.sv
package ser16_pkg;

  // Encoding of the load-phase select; the value sets the capture offset.
  typedef enum logic [1:0] {
    PH_Q3 = 2'b00,
    PH_Q2 = 2'b01,
    PH_Q1 = 2'b10,
    PH_Q0 = 2'b11
  } load_phase_t;

  // Number of quarter periods between word start and the capture cycle.
  function automatic int quarter_steps(input logic [1:0] ph);
    return 3 - int'(ph);
  endfunction

endpackage

// File: rtl/ser16_clk_sel.sv
module ser16_clk_sel (
  input  logic clk_norm,
  input  logic clk_test,
  input  logic sel_test,
  output logic clk_core
);

  // Select is registered on the normal clock; switching is expected only
  // while the core is held in reset, so no glitch protection is built in.
  logic sel_q;

  always_ff @(posedge clk_norm) begin
    sel_q <= sel_test;
  end

  assign clk_core = sel_q ? clk_test : clk_norm;

endmodule

// File: rtl/ser16_rst_sync.sv
module ser16_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/ser16_timing.sv
module ser16_timing
  import ser16_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] phase_sel,
  output logic       word_clk,
  output logic       load_pulse
);

  localparam int CNT_W   = $clog2(WORD_W);
  localparam int HALF    = WORD_W / 2;
  localparam int QUARTER = WORD_W / 4;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [1:0]       ph_q, ph_d;
  logic             wclk_q, wclk_d;
  logic [CNT_W-1:0] load_at;
  logic             word_end;

  // next-state
  always_comb begin
    word_end = (cnt_q == LAST);
    cnt_d    = word_end ? '0 : cnt_q + 1'b1;
    ph_d     = word_end ? phase_sel : ph_q;
    wclk_d   = (cnt_d < CNT_W'(HALF));
    load_at  = CNT_W'(quarter_steps(ph_q) * QUARTER);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      ph_q   <= PH_Q0;
      wclk_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_d;
      ph_q   <= ph_d;
      wclk_q <= wclk_d;
    end
  end

  assign word_clk   = wclk_q;
  assign load_pulse = rst_n & (cnt_q == load_at);

  // R2
  word_clk_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_W'(HALF)) |-> !word_clk);

  // R2
  word_clk_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0) |-> word_clk);

  // R3
  load_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_pulse |=> !load_pulse);

  // R6
  phase_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ph_q) |-> (cnt_q == '0));

endmodule

// File: rtl/ser16_shifter.sv
module ser16_shifter #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] par_in,
  output logic              msb
);

  logic [WORD_W-1:0] sh_q, sh_d;

  always_comb begin
    if (load) sh_d = par_in;
    else      sh_d = {sh_q[WORD_W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign msb = sh_q[WORD_W-1];

  // R5
  load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (sh_q == $past(par_in)));

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |-> (sh_q == '0));

endmodule

// File: rtl/ser16_tx.sv
module ser16_tx #(
  parameter int WORD_W    = 16,
  parameter int RST_STAGE = 2
) (
  input  logic              clk_bit,
  input  logic              clk_test,
  input  logic              rst_n,
  input  logic              test_clk_sel,
  input  logic              src_sel,
  input  logic [1:0]        phase_sel,
  input  logic [WORD_W-1:0] par_data,
  input  logic              byp_in,
  output logic              ser_out,
  output logic              word_clk,
  output logic              load_pulse
);

  logic clk_core;
  logic rst_core_n;
  logic load_w;
  logic sh_msb;

  ser16_clk_sel u_clk_sel (
    .clk_norm (clk_bit),
    .clk_test (clk_test),
    .sel_test (test_clk_sel),
    .clk_core (clk_core)
  );

  ser16_rst_sync #(.STAGES(RST_STAGE)) u_rst_sync (
    .clk        (clk_core),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  ser16_timing #(.WORD_W(WORD_W)) u_timing (
    .clk        (clk_core),
    .rst_n      (rst_core_n),
    .phase_sel  (phase_sel),
    .word_clk   (word_clk),
    .load_pulse (load_w)
  );

  ser16_shifter #(.WORD_W(WORD_W)) u_shifter (
    .clk    (clk_core),
    .rst_n  (rst_core_n),
    .load   (load_w),
    .par_in (par_data),
    .msb    (sh_msb)
  );

  assign load_pulse = load_w;
  // Bypass is deliberately unregistered.
  assign ser_out    = src_sel ? sh_msb : byp_in;

endmodule

// File: tb/ser16_tx_bench.sv
module ser16_tx_bench;

  logic        clk_bit = 1'b0;
  logic        clk_test = 1'b0;
  logic        rst_n = 1'b1;
  logic        test_clk_sel = 1'b0;
  logic        src_sel = 1'b1;
  logic [1:0]  phase_sel = 2'b11;
  logic [15:0] par_data = 16'h0000;
  logic        byp_in = 1'b0;
  logic        ser_out;
  logic        word_clk;
  logic        load_pulse;

  int n_chk = 0;
  int n_bad = 0;
  int tcnt = 0;
  int bcnt = 0;
  bit finished = 1'b0;

  ser16_tx u_ser16_tx (
    .clk_bit      (clk_bit),
    .clk_test     (clk_test),
    .rst_n        (rst_n),
    .test_clk_sel (test_clk_sel),
    .src_sel      (src_sel),
    .phase_sel    (phase_sel),
    .par_data     (par_data),
    .byp_in       (byp_in),
    .ser_out      (ser_out),
    .word_clk     (word_clk),
    .load_pulse   (load_pulse)
  );

  always #10 clk_bit = ~clk_bit;
  initial begin
    #5;
    forever #40 clk_test = ~clk_test;
  end

  always @(negedge clk_test) tcnt++;
  always @(negedge clk_bit)  bcnt++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_boundary;
    logic prev;
    prev = word_clk;
    @(negedge clk_bit);
    while (!(word_clk && !prev)) begin
      prev = word_clk;
      @(negedge clk_bit);
    end
  endtask

  task automatic t_reset_release;
    logic [15:0] got;
    logic        load_c12;
    got = '0;
    load_c12 = 1'b0;
    #1 rst_n = 1'b0;
    repeat (4) @(negedge clk_bit);
    check(word_clk === 1'b1,   "R1 word_clk in reset",   int'(word_clk),   1);
    check(load_pulse === 1'b0, "R1 load_pulse in reset", int'(load_pulse), 0);
    check(ser_out === 1'b0,    "R1 ser_out in reset",    int'(ser_out),    0);
    phase_sel = 2'b00;
    par_data  = 16'hA5C3;
    rst_n     = 1'b1;
    @(negedge clk_bit);
    check(load_pulse === 1'b0, "R9 no load after first edge", int'(load_pulse), 0);
    @(negedge clk_bit);
    check(load_pulse === 1'b1, "R9 load after second edge", int'(load_pulse), 1);
    for (int n = 3; n <= 18; n++) begin
      @(negedge clk_bit);
      got = {got[14:0], ser_out};
      if (n == 3)  par_data = 16'h0000;
      if (n == 14) load_c12 = load_pulse;
    end
    check(got === 16'hA5C3, "R4 R5 first word after reset", int'(got), 16'hA5C3);
    check(load_c12 === 1'b0, "R9 first word uses 0 offset", int'(load_c12), 0);
  endtask

  task automatic t_word(input logic [1:0] ph, input logic [15:0] d);
    int          lo;
    int          bad_load;
    int          bad_wclk;
    logic [15:0] got;
    lo = (3 - int'(ph)) * 4;
    bad_load = 0;
    bad_wclk = 0;
    got = '0;
    phase_sel = ph;
    par_data  = d;
    wait_boundary();
    for (int k = 0; k <= lo + 16; k++) begin
      if (k > 0) @(negedge clk_bit);
      if (load_pulse !== ((k == lo) || (k == lo + 16))) bad_load++;
      if (word_clk !== ((k % 16) < 8)) bad_wclk++;
      if (k > lo) got = {got[14:0], ser_out};
      if (k == lo + 1) par_data = ~d;
    end
    check(bad_load == 0, "R3 load position", bad_load, 0);
    check(bad_wclk == 0, "R2 word clock shape", bad_wclk, 0);
    check(got === d, "R4 R5 serial word", int'(got), int'(d));
  endtask

  task automatic t_phase_change;
    int bad;
    bad = 0;
    phase_sel = 2'b11;
    wait_boundary();
    for (int k = 0; k <= 20; k++) begin
      if (k > 0) @(negedge clk_bit);
      if (load_pulse !== ((k == 0) || (k == 20))) bad++;
      if (k == 2) phase_sel = 2'b10;
    end
    check(bad == 0, "R6 phase change at boundary", bad, 0);
  endtask

  task automatic t_bypass;
    @(negedge clk_bit);
    src_sel = 1'b0;
    byp_in  = 1'b1;
    #2;
    check(ser_out === 1'b1, "R7 bypass high", int'(ser_out), 1);
    byp_in = 1'b0;
    #2;
    check(ser_out === 1'b0, "R7 bypass low", int'(ser_out), 0);
    byp_in = 1'b1;
    #2;
    check(ser_out === 1'b1, "R7 bypass high again", int'(ser_out), 1);
    repeat (5) @(negedge clk_bit);
    src_sel = 1'b1;
    byp_in  = 1'b0;
  endtask

  task automatic t_testclk;
    int t0;
    int b0;
    @(negedge clk_bit);
    rst_n = 1'b0;
    test_clk_sel = 1'b1;
    repeat (3) @(negedge clk_bit);
    rst_n = 1'b1;
    @(posedge word_clk);
    t0 = tcnt;
    b0 = bcnt;
    @(posedge word_clk);
    check((tcnt - t0) == 16, "R8 period in test clocks", tcnt - t0, 16);
    check((bcnt - b0) == 64, "R8 bit clock ignored", bcnt - b0, 64);
    @(negedge clk_bit);
    rst_n = 1'b0;
    test_clk_sel = 1'b0;
    repeat (3) @(negedge clk_bit);
    rst_n = 1'b1;
    repeat (4) @(negedge clk_bit);
  endtask

  initial begin
    t_reset_release();
    t_word(2'b11, 16'h8001);
    t_word(2'b10, 16'h1234);
    t_word(2'b01, 16'hF0E1);
    t_word(2'b00, 16'h6A59);
    t_phase_change();
    t_bypass();
    t_word(2'b11, 16'hBEEF);
    t_testclk();
    t_word(2'b10, 16'h3C96);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule